// File: doc/BRIEF.md
# Circular Bitmap Page Allocator

This block hands out and takes back runs of I/O page-table slots. It keeps an internal occupancy bitmap with one bit per slot. A set bit means the slot is in use, and bit index n stands for a lower I/O virtual address than bit index n+1.

An allocation asks for a number of pages. That count picks a size class of 8, 16, 32 or 64 slots, and the block reserves a whole naturally aligned group of that size. The search examines one aligned group per clock. It begins at a moving hint and runs to the top of the map. It then wraps to slot 0 and continues until it returns to the group where it started. Each group is therefore examined at most once before the block reports that it is out of space.

A free names a start slot and the same page count. The block clears the matching group only if every bit of that group is set.

Requests are taken one at a time. The requester waits for the single-cycle `done` pulse before it presents the next request.

Top module: `pgalloc_bitmap`

## Requirements
- R1: An accepted allocation of 1 to 8 pages reserves an 8-slot group, 9 to 16 pages a 16-slot group, 17 to 32 pages a 32-slot group, and 33 to 64 pages a 64-slot group. Each group starts at a multiple of its size. On success `status` is 0 and `index` is the first slot of the group.
- R2: A page count of 0 or above 64 is answered with `status` 1 (bad size) one cycle after acceptance. This applies to allocations and frees alike, and the bitmap is left unchanged.
- R3: The search starts at the hint rounded down to a multiple of the group size and moves upward. After the last group of the map it continues from slot 0. The first group whose bits are all clear is taken, and all of its bits are set.
- R4: After a successful allocation the hint becomes the slot just past the granted group, or 0 if that slot is past the end of the map.
- R5: When no aligned group of the class is fully clear, the block answers with `status` 2 (full) after examining every group exactly once. Neither the bitmap nor the hint changes.
- R6: A free derives the group size from its page count and rounds the start slot down to that size. If every bit of the group is set, the group is cleared and the block answers `status` 0 with `index` equal to the rounded start slot. Otherwise it answers `status` 3 (not held) and the bitmap is left unchanged. The answer comes one cycle after acceptance, and `busy` stays low throughout.
- R7: For an allocation, `busy` is high from the cycle after acceptance until the answer. Each busy cycle examines one group. `done` pulses for one cycle, and `busy` drops on the same edge.
- R8: Requests presented while `busy` is high are ignored. When an allocation and a free are presented together, the allocation is served and the free is dropped.
- R9: Reset empties the bitmap and sets the hint to 0, with `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation request, taken when `busy` is low |
| alloc_pages | input | CNT_W | Pages requested |
| free_req | input | 1 | Free request, taken when `busy` is low and no allocation is requested |
| free_base | input | $clog2(MAP_BITS) | First slot of the run being freed |
| free_pages | input | CNT_W | Pages being freed |
| busy | output | 1 | An allocation search is in progress |
| done | output | 1 | One-cycle answer strobe |
| status | output | 2 | 0 ok, 1 bad size, 2 full, 3 not held |
| index | output | $clog2(MAP_BITS) | Group start slot, meaningful with status 0 |

## Verification
The bench builds the block with a 128-slot map, which holds sixteen 8-slot groups. At that size the map can be filled completely within a few requests. This brings exhaustion, a search that wraps past the top of the map, and a hint that wraps to 0 within a short run. The small map also makes each search length short enough to predict exactly in cycles, so the latency of every answer is compared as well as its status and index.

// File: rtl/pgalloc_pkg.sv
package pgalloc_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_class_e;

    typedef enum logic [1:0] {
        RSP_OK       = 2'd0,
        RSP_BAD_SIZE = 2'd1,
        RSP_FULL     = 2'd2,
        RSP_NOT_HELD = 2'd3
    } rsp_e;

    typedef struct packed {
        logic        legal;
        size_class_e cls;
    } class_t;

    localparam int unsigned MAX_PAGES = 64;

    // Slots covered by a group of the given class.
    function automatic int unsigned class_width(size_class_e c);
        return 32'd8 << c;
    endfunction

endpackage

// File: rtl/pga_classify.sv
module pga_classify
    import pgalloc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] pages,
    output class_t           res
);
    always_comb begin
        res.legal = (pages != '0) && (pages <= CNT_W'(MAX_PAGES));
        if (pages <= CNT_W'(8))
            res.cls = SZ_8;
        else if (pages <= CNT_W'(16))
            res.cls = SZ_16;
        else if (pages <= CNT_W'(32))
            res.cls = SZ_32;
        else
            res.cls = SZ_64;
    end
endmodule

// File: rtl/pga_group_mask.sv
module pga_group_mask
    import pgalloc_pkg::*;
#(
    parameter int unsigned MAP_BITS = 256,
    parameter int unsigned IDX_W    = 8
) (
    input  logic [IDX_W-1:0]    base,
    input  size_class_e         cls,
    output logic [MAP_BITS-1:0] mask
);
    localparam int unsigned SPAN_W = IDX_W + 1;

    logic [SPAN_W-1:0] lo;
    logic [SPAN_W-1:0] hi;

    assign lo = {1'b0, base};
    assign hi = lo + SPAN_W'(class_width(cls));

    for (genvar i = 0; i < MAP_BITS; i++) begin : g_bit
        assign mask[i] = (SPAN_W'(i) >= lo) && (SPAN_W'(i) < hi);
    end
endmodule

// File: rtl/pgalloc_bitmap.sv
module pgalloc_bitmap
    import pgalloc_pkg::*;
#(
    parameter int unsigned MAP_BITS = 256,
    parameter int unsigned CNT_W    = 8,
    localparam int unsigned IDX_W   = $clog2(MAP_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic [CNT_W-1:0] alloc_pages,
    input  logic             free_req,
    input  logic [IDX_W-1:0] free_base,
    input  logic [CNT_W-1:0] free_pages,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic [IDX_W-1:0] index
);
    localparam int unsigned PTR_W  = IDX_W + 1;
    localparam int unsigned GROUPS = MAP_BITS / 8;

    typedef enum logic {S_IDLE, S_SCAN} state_e;

    state_e              state_q;
    logic [MAP_BITS-1:0] map_q;
    logic [IDX_W-1:0]    hint_q, ptr_q, start_q;
    logic                wrapped_q;
    size_class_e         cls_q;
    logic                done_q;
    rsp_e                status_q;
    logic [IDX_W-1:0]    index_q;

    class_t alloc_cls, free_cls;

    pga_classify #(.CNT_W(CNT_W)) u_cls_alloc (.pages(alloc_pages), .res(alloc_cls));
    pga_classify #(.CNT_W(CNT_W)) u_cls_free  (.pages(free_pages),  .res(free_cls));

    // Start points rounded down to the group alignment.
    logic [IDX_W-1:0] scan_origin, free_aligned;
    assign scan_origin  = hint_q    & ~IDX_W'(class_width(alloc_cls.cls) - 1);
    assign free_aligned = free_base & ~IDX_W'(class_width(free_cls.cls) - 1);

    // One mask generator shared by the scan and the free path.
    logic [IDX_W-1:0]    mask_base;
    size_class_e         mask_cls;
    logic [MAP_BITS-1:0] grp_mask;
    assign mask_base = (state_q == S_SCAN) ? ptr_q : free_aligned;
    assign mask_cls  = (state_q == S_SCAN) ? cls_q : free_cls.cls;

    pga_group_mask #(.MAP_BITS(MAP_BITS), .IDX_W(IDX_W)) u_mask (
        .base(mask_base), .cls(mask_cls), .mask(grp_mask)
    );

    logic grp_clear, grp_held;
    assign grp_clear = (map_q & grp_mask) == '0;
    assign grp_held  = (map_q & grp_mask) == grp_mask;

    // Next group position, wrapping at the end of the map.
    logic [PTR_W-1:0] nxt;
    logic             nxt_wraps;
    logic [IDX_W-1:0] nxt_ptr;
    logic             exhausted;
    assign nxt       = {1'b0, ptr_q} + PTR_W'(class_width(cls_q));
    assign nxt_wraps = (nxt == PTR_W'(MAP_BITS));
    assign nxt_ptr   = nxt_wraps ? '0 : nxt[IDX_W-1:0];
    assign exhausted = (wrapped_q || nxt_wraps) && (nxt_ptr == start_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            map_q     <= '0;
            hint_q    <= '0;
            ptr_q     <= '0;
            start_q   <= '0;
            wrapped_q <= 1'b0;
            cls_q     <= SZ_8;
            done_q    <= 1'b0;
            status_q  <= RSP_OK;
            index_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (alloc_req) begin
                        if (!alloc_cls.legal) begin
                            done_q   <= 1'b1;
                            status_q <= RSP_BAD_SIZE;
                            index_q  <= '0;
                        end else begin
                            state_q   <= S_SCAN;
                            cls_q     <= alloc_cls.cls;
                            ptr_q     <= scan_origin;
                            start_q   <= scan_origin;
                            wrapped_q <= 1'b0;
                        end
                    end else if (free_req) begin
                        done_q <= 1'b1;
                        if (!free_cls.legal) begin
                            status_q <= RSP_BAD_SIZE;
                            index_q  <= '0;
                        end else if (!grp_held) begin
                            status_q <= RSP_NOT_HELD;
                            index_q  <= free_aligned;
                        end else begin
                            map_q    <= map_q & ~grp_mask;
                            status_q <= RSP_OK;
                            index_q  <= free_aligned;
                        end
                    end
                end
                S_SCAN: begin
                    if (grp_clear) begin
                        map_q    <= map_q | grp_mask;
                        hint_q   <= nxt_ptr;
                        done_q   <= 1'b1;
                        status_q <= RSP_OK;
                        index_q  <= ptr_q;
                        state_q  <= S_IDLE;
                    end else if (exhausted) begin
                        done_q   <= 1'b1;
                        status_q <= RSP_FULL;
                        index_q  <= '0;
                        state_q  <= S_IDLE;
                    end else begin
                        ptr_q <= nxt_ptr;
                        if (nxt_wraps) wrapped_q <= 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy   = (state_q == S_SCAN);
    assign done   = done_q;
    assign status = status_q;
    assign index  = index_q;

    // Scan-length counter used only by the bound check below.
    logic [PTR_W-1:0] scan_cnt_q;
    always_ff @(posedge clk) begin
        if (rst || state_q != S_SCAN) scan_cnt_q <= '0;
        else                          scan_cnt_q <= scan_cnt_q + 1'b1;
    end

    assert_scan_bound_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (scan_cnt_q < PTR_W'(GROUPS)));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_bad_size_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && alloc_req && (alloc_pages == '0 || alloc_pages > CNT_W'(MAX_PAGES)))
        |=> (done && status == RSP_BAD_SIZE));

    assert_free_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !alloc_req && free_req) |=> (done && !busy));

    assert_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        (done && status == RSP_OK) |-> (index[2:0] == 3'd0));

    assert_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));
endmodule

// File: tb/tb_pgalloc_bitmap.sv
module tb_pgalloc_bitmap;
    localparam int unsigned MAP_BITS = 128;
    localparam int unsigned CNT_W    = 8;
    localparam int unsigned IDX_W    = 7;

    logic             clk = 1'b0;
    logic             rst;
    logic             alloc_req;
    logic [CNT_W-1:0] alloc_pages;
    logic             free_req;
    logic [IDX_W-1:0] free_base;
    logic [CNT_W-1:0] free_pages;
    logic             busy, done;
    logic [1:0]       status;
    logic [IDX_W-1:0] index;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pgalloc_bitmap #(.MAP_BITS(MAP_BITS), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_pages(alloc_pages),
        .free_req(free_req), .free_base(free_base), .free_pages(free_pages),
        .busy(busy), .done(done), .status(status), .index(index)
    );

    // {is_free, pages, base, status, index, negedges to done, req}
    localparam int NV = 21;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 8'd1,  8'd0,  2'd0, 8'd0,  8'd2,  4'd1}, // R1 8-slot
        {1'b0, 8'd8,  8'd0,  2'd0, 8'd8,  8'd2,  4'd1}, // R1
        {1'b0, 8'd9,  8'd0,  2'd0, 8'd16, 8'd2,  4'd1}, // R1 16-slot
        {1'b0, 8'd17, 8'd0,  2'd0, 8'd32, 8'd2,  4'd1}, // R1 32-slot
        {1'b0, 8'd33, 8'd0,  2'd0, 8'd64, 8'd2,  4'd1}, // R1 64-slot, hint wraps
        {1'b0, 8'd1,  8'd0,  2'd2, 8'd0,  8'd17, 4'd5}, // R5 map full
        {1'b1, 8'd5,  8'd8,  2'd0, 8'd8,  8'd1,  4'd6}, // R6 free ok
        {1'b1, 8'd3,  8'd8,  2'd3, 8'd8,  8'd1,  4'd6}, // R6 not held
        {1'b1, 8'd10, 8'd20, 2'd0, 8'd16, 8'd1,  4'd6}, // R6 base rounded down
        {1'b0, 8'd16, 8'd0,  2'd0, 8'd16, 8'd3,  4'd3}, // R3 skips held group
        {1'b0, 8'd2,  8'd0,  2'd0, 8'd8,  8'd15, 4'd3}, // R3 wraps past top
        {1'b0, 8'd0,  8'd0,  2'd1, 8'd0,  8'd1,  4'd2}, // R2 zero pages
        {1'b0, 8'd65, 8'd0,  2'd1, 8'd0,  8'd1,  4'd2}, // R2 too many
        {1'b1, 8'd0,  8'd0,  2'd1, 8'd0,  8'd1,  4'd2}, // R2 free zero
        {1'b1, 8'd64, 8'd40, 2'd0, 8'd0,  8'd1,  4'd6}, // R6 64-slot free
        {1'b0, 8'd40, 8'd0,  2'd0, 8'd0,  8'd2,  4'd3}, // R3 hint 16 rounds to 0
        {1'b1, 8'd64, 8'd64, 2'd0, 8'd0 + 8'd64, 8'd1, 4'd6}, // R6
        {1'b0, 8'd64, 8'd0,  2'd0, 8'd64, 8'd2,  4'd4}, // R4 hint 64 used
        {1'b0, 8'd1,  8'd0,  2'd2, 8'd0,  8'd17, 4'd5}, // R5 full from hint 0
        {1'b1, 8'd64, 8'd0,  2'd0, 8'd0,  8'd1,  4'd6}, // R6
        {1'b0, 8'd8,  8'd0,  2'd0, 8'd0,  8'd2,  4'd4}  // R4 hint wrapped to 0
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp,
                       input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input logic a, input logic [7:0] ap, input logic f,
                       input logic [7:0] fb, input logic [7:0] fp,
                       output logic [1:0] st, output logic [7:0] ix, output int n);
        @(negedge clk);
        alloc_req   = a;
        alloc_pages = ap;
        free_req    = f;
        free_base   = fb[IDX_W-1:0];
        free_pages  = fp;
        n = 0;
        do begin
            @(negedge clk);
            alloc_req = 1'b0;
            free_req  = 1'b0;
            n++;
        end while (!done && n < 400);
        st = status;
        ix = {1'b0, index};
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] st;
        logic [7:0] ix;
        int         n;
        string      rq;

        rst = 1'b1; alloc_req = 1'b0; alloc_pages = '0;
        free_req = 1'b0; free_base = '0; free_pages = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9", int'(busy), 0, "busy after reset");
        chk(done == 1'b0, "R9", int'(done), 0, "done after reset");

        for (int v = 0; v < NV; v++) begin
            logic [38:0] e;
            e  = VEC[v];
            rq = $sformatf("R%0d vec%0d", e[3:0], v);
            run(!e[38], e[37:30], e[38], e[29:22], e[37:30], st, ix, n);
            chk(st == e[21:20], rq, int'(st), int'(e[21:20]), "status");
            if (e[21:20] == 2'd0)
                chk(ix == e[19:12], rq, int'(ix), int'(e[19:12]), "index");
            chk(n == int'(e[11:4]), rq, n, int'(e[11:4]), "latency (R7)");
        end
        // Map: slots 0-7 and 64-127 held, hint 8.

        run(1'b0, 8'd0, 1'b1, 8'd64, 8'd64, st, ix, n);
        chk(st == 2'd0, "R6", int'(st), 0, "free upper half");

        // R8: a free presented while busy is ignored.
        @(negedge clk);
        alloc_req = 1'b1; alloc_pages = 8'd64;
        @(negedge clk);
        alloc_req = 1'b0;
        chk(busy == 1'b1, "R7", int'(busy), 1, "busy during search");
        free_req = 1'b1; free_base = '0; free_pages = 8'd8;
        n = 1;
        do begin
            @(negedge clk);
            free_req = 1'b0;
            n++;
        end while (!done && n < 400);
        chk(status == 2'd0, "R8", int'(status), 0, "alloc status with free during busy");
        chk(index == 7'd64, "R8", int'(index), 64, "alloc index with free during busy");
        chk(n == 3, "R7", n, 3, "two-group search latency");
        run(1'b0, 8'd0, 1'b1, 8'd0, 8'd8, st, ix, n);
        chk(st == 2'd0, "R8", int'(st), 0, "group 0 still held after ignored free");

        // R8: simultaneous alloc and free, alloc wins.
        run(1'b1, 8'd8, 1'b1, 8'd64, 8'd64, st, ix, n);
        chk(st == 2'd0 && ix == 8'd0, "R8", int'(ix), 0, "alloc served over free");
        chk(n == 2, "R8", n, 2, "served as alloc latency");
        run(1'b0, 8'd0, 1'b1, 8'd64, 8'd64, st, ix, n);
        chk(st == 2'd0, "R8", int'(st), 0, "dropped free left group held");

        // R9: reset clears map and hint.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run(1'b1, 8'd1, 1'b0, 8'd0, 8'd0, st, ix, n);
        chk(st == 2'd0 && ix == 8'd0, "R9", int'(ix), 0, "first alloc after reset");
        run(1'b0, 8'd0, 1'b1, 8'd8, 8'd8, st, ix, n);
        chk(st == 2'd3, "R9", int'(st), 3, "slot 8 empty after reset");

        summary();
        $finish;
    end
endmodule